// File: doc/BRIEF.md
# Synthesizer Control and Status I2C Slave

This block is the two-wire serial control port of a frequency synthesizer. The bus master writes a frame of five bytes, the address byte and then four data bytes. Together the data bytes set every tuning control at once: a 17-bit main divider ratio, a reference ratio select, four general output port bits, the charge-pump current, the divide-by-two prescaler enable, the auxiliary output select and a test mode. A read transfer returns one status byte. It reports whether the loop is locked, whether a power-on reset has occurred since the last read, three general input levels, and a coarse 5-level ADC result that arrives from outside as a 3-bit code.

SCL and SDA are oversampled in the system clock domain. SDA is open drain: the block only ever pulls it low. A two-bit strap picks one of four bus addresses, so up to four synthesizers can share one bus. Data bytes are collected in a holding store, and the tuning outputs change only when a complete frame has been accepted. A frame that is cut short leaves the synthesizer as it was.

Top module: `synth_ctl_i2c`

## Requirements
- R1: The 7-bit bus address is binary 11000 followed by `addr_strap[1]` and `addr_strap[0]`. An address byte (address in bits 7..1, read/write flag in bit 0, 1 = read) with a matching address is acknowledged. Any other address gets no acknowledge, and the block ignores the rest of that transfer.
- R2: In a write, each of the four data bytes after the address is acknowledged. Data bytes D0..D3 in transfer order map as follows. Ratio bits 16..10 come from D0[6:0], and D0[7] is ignored. Ratio bits 9..2 come from D1. From D2: ratio bits 1..0 = D2[7:6], reference select = D2[5:4], output ports = D2[3:0]. From D3: charge-pump current = D3[7:6], prescaler enable = D3[5], auxiliary select = D3[4], test mode = D3[3:1]. D3[0] is ignored.
- R3: All tuning outputs change together, and only in the acknowledge slot of the fourth data byte. At that point the slave is pulling SDA low and SCL is high.
- R4: A write frame that ends with a stop condition before the fourth data byte leaves all tuning outputs unchanged.
- R5: A data byte after the fourth one in the same frame is not acknowledged and does not change any output.
- R6: A read returns one status byte, most significant bit first. Bit 7 is the power-on flag, bit 6 is `lock_i`, bits 5..3 are `port_in[2:0]` and bits 2..0 are the ADC code. The byte is captured when the read address has been acknowledged, and SDA is released after its last bit.
- R7: The power-on flag is 1 after reset. It clears once a status byte has been fully shifted out, and it never sets again without a reset.
- R8: ADC codes 0 to 4 are reported as they arrive. Any code above 4 is reported as 4.
- R9: SDA is only pulled low while SCL is low, and it is released on a stop condition.
- R10: After reset all tuning outputs are zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_strap | input | 2 | Low address bits select |
| lock_i | input | 1 | Loop in-lock indication |
| port_in | input | 3 | General input port levels |
| adc_code | input | 3 | ADC comparator result code |
| main_ratio | output | 17 | Main divider ratio |
| ref_sel | output | 2 | Reference ratio select |
| port_out | output | 4 | General output port states |
| cp_cur | output | 2 | Charge-pump current select |
| presc_en | output | 1 | Divide-by-two prescaler enable |
| aux_sel | output | 1 | Auxiliary output source select |
| test_mode | output | 3 | Test mode field |

## Verification
A byte counter or holding store that goes wrong shows up in two ways. The acknowledge pattern on SDA changes, and the tuning outputs move at the wrong slot or to a wrongly packed ratio. The reference model compares the outputs on every clock, so a premature or partial update is caught within a few cycles of the acknowledge edge that caused it. A fault in status capture or in the power-on flag only shows on the next read, as a wrong bit in the status byte.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

    localparam int BYTE_W      = 8;
    localparam int DATA_BYTES  = 4;
    localparam int FRAME_BITS  = DATA_BYTES * BYTE_W;
    localparam int RATIO_W     = 17;
    localparam int SYNC_STAGES = 2;
    localparam logic [4:0] ADDR_PREFIX = 5'b11000;
    localparam logic [2:0] ADC_TOP     = 3'd4;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [1:0]         ref_sel;
        logic [3:0]         port_out;
        logic [1:0]         cp_cur;
        logic               presc_en;
        logic               aux_sel;
        logic [2:0]         test_mode;
    } synth_cfg_t;

    typedef enum logic [2:0] {
        L_IDLE, L_ADDR, L_ADDR_ACK, L_WDATA, L_WACK, L_RDATA
    } link_st_e;

    // Frame vector holds the first data byte in its top bits.
    function automatic synth_cfg_t unpack_frame(input logic [FRAME_BITS-1:0] f);
        synth_cfg_t c;
        c.ratio     = {f[30:24], f[23:16], f[15:14]};
        c.ref_sel   = f[13:12];
        c.port_out  = f[11:8];
        c.cp_cur    = f[7:6];
        c.presc_en  = f[5];
        c.aux_sel   = f[4];
        c.test_mode = f[3:1];
        return c;
    endfunction

    function automatic logic [2:0] clamp_adc(input logic [2:0] code);
        return (code > ADC_TOP) ? ADC_TOP : code;
    endfunction

endpackage

// File: rtl/sctl_line_sync.sv
module sctl_line_sync
    import sctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q, scl_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    assign scl_s     = scl_pipe[SYNC_STAGES-1];
    assign sda_s     = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  =  scl_s & ~scl_q;
    assign scl_fall  = ~scl_s &  scl_q;
    assign start_det =  scl_s & scl_q &  sda_q & ~sda_s;
    assign stop_det  =  scl_s & scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/sctl_link.sv
module sctl_link
    import sctl_pkg::*;
#(
    localparam int CNT_W = $clog2(BYTE_W + 1),
    localparam int IDX_W = $clog2(DATA_BYTES + 1),
    localparam int SEL_W = $clog2(DATA_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [1:0]        addr_strap,
    input  logic [BYTE_W-1:0] status_byte,
    output logic              sda_oe,
    output logic              wr_vld,
    output logic [SEL_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              commit,
    output logic              rd_done
);
    link_st_e          st;
    logic [CNT_W-1:0]  bit_cnt;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] sh;
    logic              rw;
    logic              addr_hit, byte_done;

    assign addr_hit  = (sh[7:1] == {ADDR_PREFIX, addr_strap});
    assign byte_done = (bit_cnt == CNT_W'(BYTE_W));
    assign wr_idx    = idx[SEL_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= L_IDLE;
            bit_cnt <= '0;
            idx     <= '0;
            sh      <= '0;
            rw      <= 1'b0;
            sda_oe  <= 1'b0;
            wr_vld  <= 1'b0;
            wr_data <= '0;
            commit  <= 1'b0;
            rd_done <= 1'b0;
        end else begin
            wr_vld  <= 1'b0;
            commit  <= 1'b0;
            rd_done <= 1'b0;
            if (start_det) begin
                st      <= L_ADDR;
                bit_cnt <= '0;
                idx     <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                st     <= L_IDLE;
                sda_oe <= 1'b0;
            end else if (scl_rise) begin
                case (st)
                    L_ADDR, L_WDATA: begin
                        sh      <= {sh[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end
                    L_RDATA: bit_cnt <= bit_cnt + CNT_W'(1);
                    L_WACK:  commit  <= (idx == IDX_W'(DATA_BYTES - 1));
                    default: ;
                endcase
            end else if (scl_fall) begin
                case (st)
                    L_ADDR: if (byte_done) begin
                        bit_cnt <= '0;
                        if (addr_hit) begin
                            sda_oe <= 1'b1;
                            rw     <= sh[0];
                            st     <= L_ADDR_ACK;
                        end else begin
                            st <= L_IDLE;
                        end
                    end
                    L_ADDR_ACK: begin
                        if (rw) begin
                            st     <= L_RDATA;
                            sh     <= status_byte;
                            sda_oe <= ~status_byte[BYTE_W-1];
                        end else begin
                            st     <= L_WDATA;
                            sda_oe <= 1'b0;
                        end
                    end
                    L_WDATA: if (byte_done) begin
                        bit_cnt <= '0;
                        if (idx < IDX_W'(DATA_BYTES)) begin
                            sda_oe  <= 1'b1;
                            wr_vld  <= 1'b1;
                            wr_data <= sh;
                            st      <= L_WACK;
                        end else begin
                            st <= L_IDLE;
                        end
                    end
                    L_WACK: begin
                        sda_oe <= 1'b0;
                        idx    <= idx + IDX_W'(1);
                        st     <= L_WDATA;
                    end
                    L_RDATA: begin
                        if (byte_done) begin
                            sda_oe  <= 1'b0;
                            rd_done <= 1'b1;
                            bit_cnt <= '0;
                            st      <= L_IDLE;
                        end else begin
                            sh     <= {sh[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~sh[BYTE_W-2];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sctl_regfile.sv
module sctl_regfile
    import sctl_pkg::*;
#(
    localparam int SEL_W = $clog2(DATA_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_vld,
    input  logic [SEL_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              commit,
    input  logic              rd_done,
    input  logic              lock_i,
    input  logic [2:0]        port_in,
    input  logic [2:0]        adc_code,
    output synth_cfg_t        cfg,
    output logic [BYTE_W-1:0] status_byte,
    output logic              por
);
    logic [BYTE_W-1:0]     hold [DATA_BYTES];
    logic [FRAME_BITS-1:0] frame;

    for (genvar g = 0; g < DATA_BYTES; g++) begin : g_pack
        assign frame[(DATA_BYTES-1-g)*BYTE_W +: BYTE_W] = hold[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DATA_BYTES; i++) hold[i] <= '0;
            cfg <= '0;
            por <= 1'b1;
        end else begin
            if (wr_vld)  hold[wr_idx] <= wr_data;
            if (commit)  cfg <= unpack_frame(frame);
            if (rd_done) por <= 1'b0;
        end
    end

    assign status_byte = {por, lock_i, port_in, clamp_adc(adc_code)};
endmodule

// File: rtl/synth_ctl_i2c.sv
module synth_ctl_i2c
    import sctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [1:0]         addr_strap,
    input  logic               lock_i,
    input  logic [2:0]         port_in,
    input  logic [2:0]         adc_code,
    output logic [RATIO_W-1:0] main_ratio,
    output logic [1:0]         ref_sel,
    output logic [3:0]         port_out,
    output logic [1:0]         cp_cur,
    output logic               presc_en,
    output logic               aux_sel,
    output logic [2:0]         test_mode
);
    localparam int SEL_W = $clog2(DATA_BYTES);

    logic              sda_s_w, rise_w, fall_w, start_w, stop_w;
    logic              wr_vld_w, commit_w, rd_done_w, por_w;
    logic [SEL_W-1:0]  wr_idx_w;
    logic [BYTE_W-1:0] wr_data_w, status_w;
    synth_cfg_t        cfg_w;

    sctl_line_sync u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s_w), .scl_rise(rise_w), .scl_fall(fall_w),
        .start_det(start_w), .stop_det(stop_w)
    );

    sctl_link u_link (
        .clk(clk), .rst(rst), .sda_s(sda_s_w), .scl_rise(rise_w),
        .scl_fall(fall_w), .start_det(start_w), .stop_det(stop_w),
        .addr_strap(addr_strap), .status_byte(status_w), .sda_oe(sda_oe),
        .wr_vld(wr_vld_w), .wr_idx(wr_idx_w), .wr_data(wr_data_w),
        .commit(commit_w), .rd_done(rd_done_w)
    );

    sctl_regfile u_regs (
        .clk(clk), .rst(rst), .wr_vld(wr_vld_w), .wr_idx(wr_idx_w),
        .wr_data(wr_data_w), .commit(commit_w), .rd_done(rd_done_w),
        .lock_i(lock_i), .port_in(port_in), .adc_code(adc_code),
        .cfg(cfg_w), .status_byte(status_w), .por(por_w)
    );

    assign main_ratio = cfg_w.ratio;
    assign ref_sel    = cfg_w.ref_sel;
    assign port_out   = cfg_w.port_out;
    assign cp_cur     = cfg_w.cp_cur;
    assign presc_en   = cfg_w.presc_en;
    assign aux_sel    = cfg_w.aux_sel;
    assign test_mode  = cfg_w.test_mode;
endmodule

// File: rtl/sctl_checker.sv
module sctl_checker (
    input logic        clk,
    input logic        rst,
    input logic        scl_i,
    input logic        sda_oe,
    input logic        stop_det,
    input logic        commit,
    input logic        por,
    input logic [7:0]  status,
    input logic [16:0] main_ratio
);
    a_r9_pull_only_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_i);

    a_r9_release_on_stop: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

    a_r3_ratio_moves_on_commit: assert property (@(posedge clk) disable iff (rst)
        !$stable(main_ratio) |-> $past(commit));

    a_r3_commit_in_ack_slot: assert property (@(posedge clk) disable iff (rst)
        commit |-> sda_oe);

    a_r7_por_never_sets: assert property (@(posedge clk) disable iff (rst)
        !$rose(por));

    a_r8_adc_in_range: assert property (@(posedge clk) disable iff (rst)
        status[2:0] <= 3'd4);
endmodule

bind synth_ctl_i2c sctl_checker u_chk (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
    .stop_det(stop_w), .commit(commit_w), .por(por_w),
    .status(status_w), .main_ratio(main_ratio)
);

// File: tb/synth_ctl_i2c_bench.sv
module synth_ctl_i2c_bench;
    localparam int Q = 8;

    logic clk = 1'b0, rst = 1'b1;
    always #4 clk = ~clk;

    logic scl = 1'b1, msda = 1'b1;
    logic [1:0] strap = 2'b01;
    logic lock = 1'b0;
    logic [2:0] pin = '0, adc = '0;
    logic sda_oe;
    wire  sda_line = msda & ~sda_oe;

    logic [16:0] main_ratio;
    logic [1:0]  ref_sel, cp_cur;
    logic [3:0]  port_out;
    logic        presc_en, aux_sel;
    logic [2:0]  test_mode;

    synth_ctl_i2c u_synth_ctl_i2c (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_strap(strap), .lock_i(lock), .port_in(pin), .adc_code(adc),
        .main_ratio(main_ratio), .ref_sel(ref_sel), .port_out(port_out),
        .cp_cur(cp_cur), .presc_en(presc_en), .aux_sel(aux_sel),
        .test_mode(test_mode)
    );

    int n_tests = 0, n_fail = 0, hold_off = 0;
    logic [29:0] exp_cfg = '0, pend_cfg = '0;
    wire  [29:0] got_cfg = {main_ratio, ref_sel, port_out, cp_cur,
                            presc_en, aux_sel, test_mode};

    // Spec decode of the four data bytes (R2 layout).
    function automatic logic [29:0] decode(input logic [31:0] d);
        logic [16:0] r;
        r = {d[30:24], d[23:16], d[15:14]};
        return {r, d[13:12], d[11:8], d[7:6], d[5], d[4], d[3:1]};
    endfunction

    function automatic logic [2:0] adc_rep(input logic [2:0] a);
        return (a > 3'd4) ? 3'd4 : a;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // Reference model compared every clock (R3: outputs move only on final ack).
    always @(negedge clk) begin
        if (hold_off > 0) hold_off = hold_off - 1;
        else if (!rst) begin
            n_tests++;
            if (got_cfg !== exp_cfg) begin
                n_fail++;
                $display("FAIL R3 settings got %h exp %h", got_cfg, exp_cfg);
            end
        end
    end

    task automatic qwait();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        msda = 1'b1; qwait(); scl = 1'b1; qwait(); msda = 1'b0; qwait(); scl = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        msda = 1'b0; qwait(); scl = 1'b1; qwait(); msda = 1'b1; qwait();
        check("R9 released after stop", {31'd0, sda_oe}, 32'd0);
    endtask

    task automatic put_byte(input logic [7:0] b, input bit last, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            msda = b[i]; qwait(); scl = 1'b1; qwait(); qwait(); scl = 1'b0; qwait();
        end
        msda = 1'b1; qwait(); scl = 1'b1;
        if (last) begin exp_cfg = pend_cfg; hold_off = 6; end
        qwait(); acked = (sda_line == 1'b0); qwait(); scl = 1'b0; qwait();
    endtask

    task automatic get_byte(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            msda = 1'b1; qwait(); scl = 1'b1; qwait(); b[i] = sda_line; qwait(); scl = 1'b0; qwait();
        end
        msda = 1'b1; qwait(); scl = 1'b1; qwait(); qwait(); scl = 1'b0; qwait();
    endtask

    task automatic write_frame(input logic [1:0] a, input logic [31:0] d, input int nsend);
        bit ack;
        bus_start();
        put_byte({5'b11000, a, 1'b0}, 1'b0, ack);
        check("R1 write address ack", {31'd0, ack}, 32'd1);
        if (nsend >= 4) pend_cfg = decode(d);
        for (int i = 0; i < nsend; i++) begin
            put_byte((i < 4) ? d[31-8*i -: 8] : 8'hA5, i == 3, ack);
            if (i < 4) check("R2 data byte ack", {31'd0, ack}, 32'd1);
            else       check("R5 extra byte nack", {31'd0, ack}, 32'd0);
        end
        bus_stop();
    endtask

    task automatic read_status(input logic [7:0] exp);
        bit ack;
        logic [7:0] st;
        bus_start();
        put_byte({5'b11000, strap, 1'b1}, 1'b0, ack);
        check("R1 read address ack", {31'd0, ack}, 32'd1);
        get_byte(st);
        check("R6 R7 R8 status byte", {24'd0, st}, {24'd0, exp});
        bus_stop();
    endtask

    initial begin
        bit ack;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R10 reset settings", {2'd0, got_cfg}, 32'd0);
        check("R10 reset sda", {31'd0, sda_oe}, 32'd0);

        lock = 1'b1; pin = 3'b101; adc = 3'd3;
        read_status({1'b1, 1'b1, 3'b101, 3'd3});          // R7 flag set after reset
        lock = 1'b0; pin = 3'b010; adc = 3'd6;
        read_status({1'b0, 1'b0, 3'b010, adc_rep(3'd6)}); // R7 cleared, R8 clamp
        adc = 3'd4;
        read_status({1'b0, 1'b0, 3'b010, 3'd4});

        write_frame(strap, 32'h5AC396E5, 4);
        check("R2 decoded settings", {2'd0, got_cfg}, {2'd0, decode(32'h5AC396E5)});

        write_frame(strap, 32'h01020304, 2);               // R4 cut short
        check("R4 partial two bytes", {2'd0, got_cfg}, {2'd0, decode(32'h5AC396E5)});
        write_frame(strap, 32'h7E6D5C4B, 3);
        check("R4 partial three bytes", {2'd0, got_cfg}, {2'd0, decode(32'h5AC396E5)});

        write_frame(strap, 32'h7FFFFFFF, 5);               // R5 extra byte
        check("R5 settings after extra", {2'd0, got_cfg}, {2'd0, decode(32'h7FFFFFFF)});

        strap = 2'b10;
        bus_start();
        put_byte({5'b11000, 2'b01, 1'b0}, 1'b0, ack);
        check("R1 foreign address nack", {31'd0, ack}, 32'd0);
        bus_stop();
        write_frame(2'b10, 32'h80102031, 4);
        check("R1 R2 new strap frame", {2'd0, got_cfg}, {2'd0, decode(32'h80102031)});

        repeat (20) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired got running exp finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule